// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This unit sits beside the control sequencer of an 8-bit processor core and decides, at each instruction boundary, whether the core must enter an exception routine, and which one. It weighs reset, an edge-triggered non-maskable request pin, a fast maskable request pin, a normal maskable request pin, and three software traps raised by the instruction decoder. The condition-code mask bits I and F come in from the datapath and are read only at the boundary.

When an entry is chosen, the unit gives a one-cycle accept pulse one clock after the boundary. With the pulse it gives the source code, the 16-bit address of the high byte of the vector (the low byte is read from the next address), a flag that asks for all registers to be stacked rather than only the program counter and condition codes, and the I and F bits that the datapath must set. Stacking, vector fetch and return from the routine belong to the core and are not part of this unit.

Top module: `intr_seq_top`

## Requirements
- R1: On an accept, `src_code` gives the entry type (1 reset, 2 non-maskable, 3 trap level 1, 4 normal, 5 fast, 6 trap level 2, 7 trap level 3) and `vec_addr` equals 0x10000 minus twice that code (0xFFFE down to 0xFFF2). When `take` is low, `src_code`, `vec_addr`, `stack_all`, `set_i` and `set_f` are all zero.
- R2: Apart from the reset entry, `take` rises only in the cycle after a cycle with `insn_done` high. Pin requests present while `insn_done` is low cause no accept until a boundary.
- R3: The non-maskable pin `nmi_n` triggers on a high-to-low transition only, whatever I and F are. A pin held low gives one entry, not one per boundary.
- R4: A falling edge on `nmi_n` is held pending until it is accepted, so a low pulse that ends before the next boundary is still taken at that boundary.
- R5: The normal request is taken at a boundary when `irq_n` is low and `mask_i` is 0. Its entry sets I only and requests full stacking.
- R6: The fast request is taken at a boundary when `firq_n` is low and `mask_f` is 0. Its entry sets both I and F and requests partial stacking (`stack_all` = 0).
- R7: When several requests meet at one boundary, the order is: software trap, then non-maskable, then fast, then normal. A request that loses stays pending (edge latch) or stays present (level) for a later boundary.
- R8: `trap_sel` at a boundary raises a trap (01 level 1, 10 level 2, 11 level 3, 00 none). Every trap requests full stacking. Level 1 sets I and F. Levels 2 and 3 set neither.
- R9: A non-maskable entry sets I and F and requests full stacking.
- R10: In the first cycle after `rst_n` is released, the unit gives a reset entry (code 1, sets I and F, no stacking) whatever the other inputs are. Reset discards any non-maskable edge that was pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_done | input | 1 | High for one cycle at an instruction boundary |
| trap_sel | input | 2 | Software trap level raised by the ending instruction; 00 for none |
| nmi_n | input | 1 | Non-maskable request, active falling edge |
| firq_n | input | 1 | Fast request, active low level |
| irq_n | input | 1 | Normal request, active low level |
| mask_i | input | 1 | Current I bit of the condition codes |
| mask_f | input | 1 | Current F bit of the condition codes |
| take | output | 1 | One-cycle accept pulse |
| src_code | output | 3 | Code of the accepted entry |
| vec_addr | output | 16 | Address of the vector high byte |
| stack_all | output | 1 | 1 asks for all registers to be stacked, 0 for PC and CC only |
| set_i | output | 1 | Datapath sets I on this entry |
| set_f | output | 1 | Datapath sets F on this entry |

## Verification
Two events can land on the same boundary. The first case is a software trap ending an instruction in the same cycle that the non-maskable pin falls. The second is the fast and normal levels both being low with both masks clear. The bench drives the edge or the levels together with `insn_done`. It expects the trap, or the fast entry, to win on that boundary, and the non-maskable edge to come out at the next boundary. A reset applied while an edge is pending is judged by the absence of any non-maskable entry afterwards.

// File: rtl/intr_seq_pkg.sv
// Shared types for the interrupt entry sequencer.
// Assumes the source codes double as the vector offset index (vector = top - 2*(code-1)).
package intr_seq_pkg;

    typedef enum logic [2:0] {
        SRC_NONE  = 3'd0,
        SRC_RST   = 3'd1,
        SRC_NMI   = 3'd2,
        SRC_TRAP1 = 3'd3,
        SRC_IRQ   = 3'd4,
        SRC_FIRQ  = 3'd5,
        SRC_TRAP2 = 3'd6,
        SRC_TRAP3 = 3'd7
    } src_e;

    typedef struct packed {
        logic take;
        src_e src;
        logic stack_all;
        logic set_i;
        logic set_f;
    } entry_t;

    // Build the full entry record for one source; SRC_NONE yields all zeros.
    function automatic entry_t entry_of(input src_e s);
        entry_t e;
        e.take      = (s != SRC_NONE);
        e.src       = s;
        e.stack_all = (s == SRC_NMI) || (s == SRC_TRAP1) || (s == SRC_IRQ) ||
                      (s == SRC_TRAP2) || (s == SRC_TRAP3);
        e.set_i     = (s == SRC_RST) || (s == SRC_NMI) || (s == SRC_TRAP1) ||
                      (s == SRC_IRQ) || (s == SRC_FIRQ);
        e.set_f     = (s == SRC_RST) || (s == SRC_NMI) || (s == SRC_TRAP1) ||
                      (s == SRC_FIRQ);
        return e;
    endfunction

endpackage

// File: rtl/intr_nmi_catch.sv
// Non-maskable edge catcher.
// Detects a high-to-low transition of the active-low pin and holds it in a sticky
// latch until the arbiter accepts it. The output already includes an edge seen this
// cycle, so an edge arriving on a boundary is taken on that boundary.
// Assumes nmi_n is already synchronous to clk.
module intr_nmi_catch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_n,
    input  logic accept,
    output logic pend
);

    logic nmi_prev;
    logic held;
    logic fall;

    assign fall = nmi_prev & ~nmi_n;
    assign pend = held | fall;

    // Track the pin level of the previous cycle (also during reset, so a pin held low is no edge).
    always_ff @(posedge clk) begin
        nmi_prev <= nmi_n;
    end

    // Sticky latch: a new edge survives the consumption of an older one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= 1'b0;
        end else if (accept) begin
            held <= held & fall;
        end else if (fall) begin
            held <= 1'b1;
        end
    end

    AST_NMI_HELD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !accept) |=> held); // R4

    AST_NMI_ACCEPT_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> pend); // R3

endmodule

// File: rtl/intr_arbiter.sv
// Fixed-priority chooser for one instruction boundary.
// Ranks requests trap > non-maskable > fast > normal and returns the winning source,
// or SRC_NONE when not at a boundary or nothing qualifies.
// Assumes trap_sel is only meaningful together with boundary.
module intr_arbiter
    import intr_seq_pkg::*;
(
    input  logic       boundary,
    input  logic [1:0] trap_sel,
    input  logic       nmi_pend,
    input  logic       firq_n,
    input  logic       irq_n,
    input  logic       mask_i,
    input  logic       mask_f,
    output src_e       pick
);

    localparam int RANKS = 6;

    logic [RANKS-1:0] req;

    // Map a rank index to its source; rank 0 is the highest priority.
    function automatic src_e rank_src(input int r);
        case (r)
            0:       return SRC_TRAP1;
            1:       return SRC_TRAP2;
            2:       return SRC_TRAP3;
            3:       return SRC_NMI;
            4:       return SRC_FIRQ;
            default: return SRC_IRQ;
        endcase
    endfunction

    // Qualify each request with its mask, in rank order.
    always_comb begin
        req[0] = (trap_sel == 2'b01);
        req[1] = (trap_sel == 2'b10);
        req[2] = (trap_sel == 2'b11);
        req[3] = nmi_pend;
        req[4] = ~firq_n & ~mask_f;
        req[5] = ~irq_n & ~mask_i;
    end

    // Scan from lowest to highest priority so the highest set rank wins.
    always_comb begin
        pick = SRC_NONE;
        if (boundary) begin
            for (int r = RANKS - 1; r >= 0; r--) begin
                if (req[r]) pick = rank_src(r);
            end
        end
    end

endmodule

// File: rtl/intr_entry_reg.sv
// Output register of the sequencer.
// Holds the entry record for one cycle after the decision, and injects the reset
// entry in the first cycle after reset release. While that reset entry is pending it
// raises rst_blk so that no other decision is made in the same cycle.
module intr_entry_reg
    import intr_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  src_e   pick,
    output entry_t ent,
    output logic   rst_blk
);

    // Register the chosen entry; reset entry takes precedence on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_blk <= 1'b1;
            ent     <= '0;
        end else if (rst_blk) begin
            rst_blk <= 1'b0;
            ent     <= entry_of(SRC_RST);
        end else begin
            ent     <= entry_of(pick);
        end
    end

    AST_RESET_ENTRY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        rst_blk |=> (ent.take && ent.src == SRC_RST && !ent.stack_all && ent.set_i && ent.set_f)); // R10

    AST_FAST_PARTIAL_STACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ent.take && ent.src == SRC_FIRQ) |-> (!ent.stack_all && ent.set_i && ent.set_f)); // R6

    AST_NORMAL_SETS_I_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (ent.take && ent.src == SRC_IRQ) |-> (ent.stack_all && ent.set_i && !ent.set_f)); // R5

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !ent.take |-> (ent.src == SRC_NONE && !ent.stack_all && !ent.set_i && !ent.set_f)); // R1

endmodule

// File: rtl/intr_seq_top.sv
// Interrupt entry sequencer top.
// Samples requests at instruction boundaries (insn_done), picks one entry by fixed
// priority, and presents a one-cycle accept with vector address, stacking depth and
// mask updates one clock later. Mask bits are owned by the datapath and fed back in.
module intr_seq_top
    import intr_seq_pkg::*;
#(
    parameter int            VEC_W   = 16,
    parameter logic [15:0]   VEC_TOP = 16'hFFFE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             insn_done,
    input  logic [1:0]       trap_sel,
    input  logic             nmi_n,
    input  logic             firq_n,
    input  logic             irq_n,
    input  logic             mask_i,
    input  logic             mask_f,
    output logic             take,
    output logic [2:0]       src_code,
    output logic [VEC_W-1:0] vec_addr,
    output logic             stack_all,
    output logic             set_i,
    output logic             set_f
);

    localparam logic [VEC_W-1:0] VEC_BASE = VEC_W'(VEC_TOP) + VEC_W'(2);

    logic   nmi_pend;
    logic   nmi_accept;
    logic   rst_blk;
    logic   boundary;
    src_e   pick;
    entry_t ent;

    assign boundary   = insn_done & ~rst_blk;
    assign nmi_accept = (pick == SRC_NMI);

    intr_nmi_catch u_nmi (
        .clk    (clk),
        .rst_n  (rst_n),
        .nmi_n  (nmi_n),
        .accept (nmi_accept),
        .pend   (nmi_pend)
    );

    intr_arbiter u_arb (
        .boundary (boundary),
        .trap_sel (trap_sel),
        .nmi_pend (nmi_pend),
        .firq_n   (firq_n),
        .irq_n    (irq_n),
        .mask_i   (mask_i),
        .mask_f   (mask_f),
        .pick     (pick)
    );

    intr_entry_reg u_ent (
        .clk     (clk),
        .rst_n   (rst_n),
        .pick    (pick),
        .ent     (ent),
        .rst_blk (rst_blk)
    );

    // Drive the port view of the entry; vector steps down two bytes per code.
    always_comb begin
        take      = ent.take;
        src_code  = ent.src;
        stack_all = ent.stack_all;
        set_i     = ent.set_i;
        set_f     = ent.set_f;
        vec_addr  = ent.take ? (VEC_BASE - (VEC_W'(ent.src) << 1)) : '0;
    end

    AST_ACCEPT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (take && src_code != SRC_RST) |-> $past(insn_done)); // R2

    AST_NORMAL_MASK_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (take && src_code == SRC_IRQ) |-> $past(!mask_i && !irq_n)); // R5

    AST_FAST_MASK_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (take && src_code == SRC_FIRQ) |-> $past(!mask_f && !firq_n)); // R6

    AST_TRAP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (take && src_code != SRC_RST && $past(insn_done && trap_sel != 2'b00))
            |-> (src_code == SRC_TRAP1 || src_code == SRC_TRAP2 || src_code == SRC_TRAP3)); // R7

    AST_NMI_FULL_STACK: assert property (@(posedge clk) disable iff (!rst_n)
        (take && src_code == SRC_NMI) |-> (stack_all && set_i && set_f)); // R9

endmodule

// File: tb/intr_seq_top_tb_top.sv
// Scoreboard bench: the boundary driver predicts each outcome into a queue, the
// monitor pops and compares at the falling edge after every due cycle.
module intr_seq_top_tb_top;

    typedef struct packed {
        logic        take;
        logic [2:0]  src;
        logic [15:0] vec;
        logic        stk;
        logic        si;
        logic        sf;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_done = 1'b0;
    logic [1:0]  trap_sel = 2'b00;
    logic        nmi_n = 1'b1;
    logic        firq_n = 1'b1;
    logic        irq_n = 1'b1;
    logic        mask_i = 1'b1;
    logic        mask_f = 1'b1;
    logic        take;
    logic [2:0]  src_code;
    logic [15:0] vec_addr;
    logic        stack_all;
    logic        set_i;
    logic        set_f;

    int   n_chk = 0;
    int   n_bad = 0;
    logic model_nmi = 1'b0;
    logic due_q = 1'b0;
    logic rst_q = 1'b0;
    exp_t exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    intr_seq_top dut_i (
        .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .trap_sel(trap_sel),
        .nmi_n(nmi_n), .firq_n(firq_n), .irq_n(irq_n), .mask_i(mask_i), .mask_f(mask_f),
        .take(take), .src_code(src_code), .vec_addr(vec_addr), .stack_all(stack_all),
        .set_i(set_i), .set_f(set_f)
    );

    // Expected record for a code, from the requirement tables (R1, R5, R6, R8, R9, R10).
    function automatic exp_t exp_of(input logic [2:0] c);
        exp_t e;
        e.take = (c != 3'd0);
        e.src  = c;
        e.vec  = e.take ? 16'(17'h10000 - 17'(c) * 17'd2) : 16'h0000;
        e.stk  = (c == 3'd2) || (c == 3'd3) || (c == 3'd4) || (c == 3'd6) || (c == 3'd7);
        e.si   = (c >= 3'd1) && (c <= 3'd5);
        e.sf   = (c == 3'd1) || (c == 3'd2) || (c == 3'd3) || (c == 3'd5);
        return e;
    endfunction

    // Mark cycles whose result is due on the following falling edge.
    always @(posedge clk) begin
        due_q <= insn_done | (rst_n & ~rst_q);
        rst_q <= rst_n;
    end

    // Monitor: compare due cycles against the queue, and flag any stray accept.
    always @(negedge clk) begin
        if (due_q) begin
            exp_t  e;
            string t;
            if (exp_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R2: result with empty queue, take=%0b src=%0d", take, src_code);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_chk++;
                if ({take, src_code, vec_addr, stack_all, set_i, set_f} !== e) begin
                    n_bad++;
                    $display("FAIL %s: got take=%0b src=%0d vec=%h stk=%0b i=%0b f=%0b, exp take=%0b src=%0d vec=%h stk=%0b i=%0b f=%0b",
                             t, take, src_code, vec_addr, stack_all, set_i, set_f,
                             e.take, e.src, e.vec, e.stk, e.si, e.sf);
                end
            end
        end else if (rst_n && rst_q && take) begin
            n_chk++; n_bad++;
            $display("FAIL R2: accept off boundary, got take=1 src=%0d, exp take=0", src_code);
        end
    end

    // Drive one boundary and push the predicted outcome; called and returns just after a falling edge.
    task automatic bnd(input logic [1:0] ts, input string tag);
        logic [2:0] c;
        if (ts == 2'b01)                 c = 3'd3;
        else if (ts == 2'b10)            c = 3'd6;
        else if (ts == 2'b11)            c = 3'd7;
        else if (model_nmi)              c = 3'd2;
        else if (!firq_n && !mask_f)     c = 3'd5;
        else if (!irq_n && !mask_i)      c = 3'd4;
        else                             c = 3'd0;
        if (ts == 2'b00 && c == 3'd2) model_nmi = 1'b0;
        exp_q.push_back(exp_of(c));
        tag_q.push_back(tag);
        trap_sel  = ts;
        insn_done = 1'b1;
        @(negedge clk);
        insn_done = 1'b0;
        trap_sel  = 2'b00;
        @(negedge clk);
    endtask

    // Set the non-maskable pin, recording a falling edge in the model.
    task automatic nmi_set(input logic v);
        if (nmi_n && !v) model_nmi = 1'b1;
        nmi_n = v;
    endtask

    // Apply reset for a few cycles and expect the reset entry on release.
    task automatic do_reset();
        rst_n = 1'b0;
        model_nmi = 1'b0;
        repeat (3) @(negedge clk);
        n_chk++;
        if (take !== 1'b0 || vec_addr !== 16'h0000) begin
            n_bad++;
            $display("FAIL R10: in reset got take=%0b vec=%h, exp take=0 vec=0000", take, vec_addr);
        end
        exp_q.push_back(exp_of(3'd1));
        tag_q.push_back("R10 reset entry");
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1 / R11-style idle: boundary with nothing pending gives all-zero outputs
        mask_i = 1'b0; mask_f = 1'b0;
        bnd(2'b00, "R1 idle boundary");

        // R5 level normal request, taken twice while held low
        irq_n = 1'b0;
        bnd(2'b00, "R5 normal taken");
        bnd(2'b00, "R5 normal level again");

        // R2 no accept without a boundary (monitor flags strays); explicit check too
        repeat (4) @(negedge clk);
        n_chk++;
        if (take !== 1'b0) begin
            n_bad++;
            $display("FAIL R2: got take=%0b between boundaries, exp 0", take);
        end

        // R5 masked by I
        mask_i = 1'b1;
        bnd(2'b00, "R5 normal masked");

        // R7 fast beats normal; R6 fast entry shape
        mask_i = 1'b0; firq_n = 1'b0;
        bnd(2'b00, "R7 fast over normal");

        // R6 fast blocked by F, normal still taken
        mask_f = 1'b1;
        bnd(2'b00, "R6 fast masked normal taken");
        irq_n = 1'b1;
        bnd(2'b00, "R6 fast masked alone");

        // R3 R9 edge at the boundary, masks set; held low gives no second entry
        mask_i = 1'b1; firq_n = 1'b1;
        nmi_set(1'b0);
        bnd(2'b00, "R9 nmi ignores masks");
        bnd(2'b00, "R3 nmi held low no retrigger");
        nmi_set(1'b1);
        @(negedge clk);

        // R4 short pulse between boundaries is kept
        nmi_set(1'b0); @(negedge clk);
        nmi_set(1'b1); @(negedge clk);
        repeat (3) @(negedge clk);
        bnd(2'b00, "R4 nmi pulse latched");

        // R7 trap and nmi edge on the same boundary, fast also present
        mask_f = 1'b0; firq_n = 1'b0;
        nmi_set(1'b0);
        bnd(2'b01, "R7 trap1 over nmi");
        bnd(2'b00, "R7 nmi next");
        bnd(2'b00, "R7 fast after nmi");
        nmi_set(1'b1); firq_n = 1'b1;
        @(negedge clk);

        // R8 trap levels
        mask_i = 1'b1; mask_f = 1'b1;
        bnd(2'b10, "R8 trap2");
        bnd(2'b11, "R8 trap3");
        bnd(2'b01, "R8 trap1");

        // R10 reset discards a pending edge
        nmi_set(1'b0); @(negedge clk);
        nmi_set(1'b1); @(negedge clk);
        do_reset();
        bnd(2'b00, "R10 pending nmi cleared");

        repeat (4) @(negedge clk);
        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R2: %0d results missing, exp 0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule